// File: doc/BRIEF.md
# Per-Pin Selectable Chip-Select Output Port

This block is an eight-bit, output-only port for a small microcontroller bus. Each pin is either a general-purpose output driven by a data register, or an active-low chip-select line driven by a built-in address decoder. A mode register has one bit per pin and makes that choice for each pin. The port has no direction register, because every pin is always an output.

Software reaches the two registers over a simple register interface, at byte offsets 0x23 (data) and 0x27 (mode). The decoder compares the current bus address against eight fixed windows. A pin in chip-select mode goes low only while a valid access falls inside its window.

Reset puts every pin in data mode with a high level, so no external device is selected. A typical boot sequence then writes 0xFB to the mode register. Pin 2 stays under data-register control, and a 1 in that data bit keeps pin 2 deasserted.

Top module: `cs_port`

## Requirements
- R1: After synchronous reset the mode register reads 0x00, the data register reads 0xFF, and every pin is high.
- R2: A pin whose mode bit is 0 drives the corresponding data register bit.
- R3: A pin whose mode bit is 1 drives its chip-select level, and its data register bit has no effect on the pin.
- R4: Chip-select n is low exactly when `bus_valid` is 1 and `bus_addr` lies in window n. The default windows are: n0 0x0000-0x0FFF, n1 0x1000-0x1FFF, n2 0x2000-0x3FFF, n3 0x8000-0xFFFF, n4 0x4000-0x4FFF, n5 0x5000-0x5FFF, n6 0x6000-0x6FFF, n7 0x7000-0x7FFF. The default windows do not overlap, so at most one select is low at a time.
- R5: While `bus_valid` is 0, every chip-select level is high. A pin in chip-select mode therefore reads high during idle cycles.
- R6: A register write happens on the rising clock edge when `reg_sel` and `reg_we` are both 1. Offset 0x23 writes the data register and offset 0x27 writes the mode register. The new value reaches the pins in the next cycle.
- R7: A write with `reg_sel` at 0, or a write to any other offset, changes neither register.
- R8: While `reg_sel` is 1 and `reg_we` is 0, `reg_rdata` returns the stored register at the addressed offset in the same cycle, and 0x00 for any other offset. Otherwise it is 0x00. A read of the data register returns the stored value, not the pin level.
- R9: With the mode register at 0xFB, pins 0, 1 and 3-7 act as chip selects, and pin 2 follows data bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A bus access is in progress this cycle |
| bus_addr | input | 16 | Bus address being decoded |
| reg_sel | input | 1 | Register interface selected |
| reg_we | input | 1 | Write strobe for the register interface |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| pin_out | output | 8 | Port pin levels |

## Verification
The one-hot check on the selects assumes the default windows, which do not overlap. The stimulus keeps to those windows and checks the levels at both edges of each window. The register assertions assume that `reg_addr` is stable whenever `reg_sel` is 1. The bench changes every input only at the falling clock edge, so this holds. Address sweeps run with `bus_valid` both high and low under several mode/data pairs. This keeps the idle-high property exercised alongside the decode.

// File: rtl/cs_port_pkg.sv
package cs_port_pkg;

    localparam int DEF_ADDR_W = 16;
    localparam int DEF_PORT_W = 8;
    localparam int DEF_REG_AW = 8;

    // Window n occupies bits [n*16 +: 16]; match when (addr & mask) == base.
    localparam logic [DEF_PORT_W*DEF_ADDR_W-1:0] DEF_WIN_BASE = {
        16'h7000, 16'h6000, 16'h5000, 16'h4000,
        16'h8000, 16'h2000, 16'h1000, 16'h0000
    };
    localparam logic [DEF_PORT_W*DEF_ADDR_W-1:0] DEF_WIN_MASK = {
        16'hF000, 16'hF000, 16'hF000, 16'hF000,
        16'h8000, 16'hE000, 16'hF000, 16'hF000
    };

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_DATA = 2'd1,
        TGT_MODE = 2'd2
    } reg_target_e;

endpackage

// File: rtl/cs_port_regs.sv
module cs_port_regs
    import cs_port_pkg::*;
#(
    parameter int                PORT_W   = DEF_PORT_W,
    parameter int                REG_AW   = DEF_REG_AW,
    parameter logic [REG_AW-1:0] OFS_DATA = 8'h23,
    parameter logic [REG_AW-1:0] OFS_MODE = 8'h27
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [PORT_W-1:0] reg_wdata,
    output logic [PORT_W-1:0] reg_rdata,
    output logic [PORT_W-1:0] dat_q,
    output logic [PORT_W-1:0] mode_q
);

    reg_target_e tgt;

    always_comb begin
        if (!reg_sel)                 tgt = TGT_NONE;
        else if (reg_addr == OFS_DATA) tgt = TGT_DATA;
        else if (reg_addr == OFS_MODE) tgt = TGT_MODE;
        else                          tgt = TGT_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dat_q  <= '1;
            mode_q <= '0;
        end else if (reg_we) begin
            if (tgt == TGT_DATA) dat_q  <= reg_wdata;
            if (tgt == TGT_MODE) mode_q <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (!reg_we) begin
            case (tgt)
                TGT_DATA: reg_rdata = dat_q;
                TGT_MODE: reg_rdata = mode_q;
                default:  reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/cs_port_decode.sv
module cs_port_decode
    import cs_port_pkg::*;
#(
    parameter int                          ADDR_W   = DEF_ADDR_W,
    parameter int                          NUM_SEL  = DEF_PORT_W,
    parameter logic [NUM_SEL*ADDR_W-1:0]   WIN_BASE = DEF_WIN_BASE,
    parameter logic [NUM_SEL*ADDR_W-1:0]   WIN_MASK = DEF_WIN_MASK
) (
    input  logic               bus_valid,
    input  logic [ADDR_W-1:0]  bus_addr,
    output logic [NUM_SEL-1:0] cs_n
);

    for (genvar n = 0; n < NUM_SEL; n++) begin : g_win
        localparam logic [ADDR_W-1:0] BASE = WIN_BASE[n*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] MASK = WIN_MASK[n*ADDR_W +: ADDR_W];
        logic hit;
        assign hit     = ((bus_addr & MASK) == BASE);
        assign cs_n[n] = !(bus_valid && hit);
    end

endmodule

// File: rtl/cs_port_mux.sv
module cs_port_mux
    import cs_port_pkg::*;
#(
    parameter int PORT_W = DEF_PORT_W
) (
    input  logic [PORT_W-1:0] mode_q,
    input  logic [PORT_W-1:0] dat_q,
    input  logic [PORT_W-1:0] cs_n,
    output logic [PORT_W-1:0] pin_out
);

    for (genvar b = 0; b < PORT_W; b++) begin : g_pin
        assign pin_out[b] = mode_q[b] ? cs_n[b] : dat_q[b];
    end

endmodule

// File: rtl/cs_port.sv
module cs_port
    import cs_port_pkg::*;
#(
    parameter int                        ADDR_W   = DEF_ADDR_W,
    parameter int                        PORT_W   = DEF_PORT_W,
    parameter int                        REG_AW   = DEF_REG_AW,
    parameter logic [REG_AW-1:0]         OFS_DATA = 8'h23,
    parameter logic [REG_AW-1:0]         OFS_MODE = 8'h27,
    parameter logic [PORT_W*ADDR_W-1:0]  WIN_BASE = DEF_WIN_BASE,
    parameter logic [PORT_W*ADDR_W-1:0]  WIN_MASK = DEF_WIN_MASK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [PORT_W-1:0] reg_wdata,
    output logic [PORT_W-1:0] reg_rdata,
    output logic [PORT_W-1:0] pin_out
);

    logic [PORT_W-1:0] dat_q;
    logic [PORT_W-1:0] mode_q;
    logic [PORT_W-1:0] cs_n;

    cs_port_regs #(
        .PORT_W(PORT_W), .REG_AW(REG_AW),
        .OFS_DATA(OFS_DATA), .OFS_MODE(OFS_MODE)
    ) u_regs (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dat_q(dat_q), .mode_q(mode_q)
    );

    cs_port_decode #(
        .ADDR_W(ADDR_W), .NUM_SEL(PORT_W),
        .WIN_BASE(WIN_BASE), .WIN_MASK(WIN_MASK)
    ) u_dec (
        .bus_valid(bus_valid), .bus_addr(bus_addr), .cs_n(cs_n)
    );

    cs_port_mux #(
        .PORT_W(PORT_W)
    ) u_mux (
        .mode_q(mode_q), .dat_q(dat_q), .cs_n(cs_n), .pin_out(pin_out)
    );

endmodule

// File: rtl/cs_port_chk.sv
module cs_port_chk #(
    parameter int                PORT_W   = 8,
    parameter int                REG_AW   = 8,
    parameter logic [REG_AW-1:0] OFS_DATA = 8'h23,
    parameter logic [REG_AW-1:0] OFS_MODE = 8'h27
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              reg_sel,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [PORT_W-1:0] reg_wdata,
    input logic [PORT_W-1:0] dat_q,
    input logic [PORT_W-1:0] mode_q,
    input logic [PORT_W-1:0] cs_n,
    input logic [PORT_W-1:0] pin_out
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_q == '0 && dat_q == '1 && pin_out == '1));

    // R4
    single_select_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    // R5
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |-> (cs_n == '1));

    // R3
    all_cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == '1 && !bus_valid) |-> (pin_out == '1));

    // R6
    data_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && reg_we && reg_addr == OFS_DATA) |=> (dat_q == $past(reg_wdata)));

    // R6
    mode_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && reg_we && reg_addr == OFS_MODE) |=> (mode_q == $past(reg_wdata)));

    // R7
    no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_sel && reg_we) |=> ($stable(dat_q) && $stable(mode_q)));

endmodule

bind cs_port cs_port_chk #(
    .PORT_W(PORT_W), .REG_AW(REG_AW), .OFS_DATA(OFS_DATA), .OFS_MODE(OFS_MODE)
) u_chk (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .reg_sel(reg_sel),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .dat_q(dat_q), .mode_q(mode_q), .cs_n(cs_n), .pin_out(pin_out)
);

// File: tb/cs_port_tb.sv
module cs_port_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_valid = 1'b0;
    logic [15:0] bus_addr = '0;
    logic       reg_sel = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] pin_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_dat = 8'hFF;
    logic [7:0] m_mode = 8'h00;

    always #2 clk = ~clk;

    cs_port u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_out(pin_out)
    );

    function automatic logic [7:0] ref_cs_n(input logic v, input logic [15:0] a);
        logic [7:0] r;
        r = 8'hFF;
        if (v) begin
            if (a <= 16'h0FFF)                        r[0] = 1'b0;
            else if (a <= 16'h1FFF)                   r[1] = 1'b0;
            else if (a <= 16'h3FFF)                   r[2] = 1'b0;
            else if (a >= 16'h8000)                   r[3] = 1'b0;
            else if (a <= 16'h4FFF)                   r[4] = 1'b0;
            else if (a <= 16'h5FFF)                   r[5] = 1'b0;
            else if (a <= 16'h6FFF)                   r[6] = 1'b0;
            else                                      r[7] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [7:0] ref_pins(input logic v, input logic [15:0] a);
        return (m_mode & ref_cs_n(v, a)) | (~m_mode & m_dat);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] ofs, input logic [7:0] val, input logic sel);
        @(negedge clk);
        reg_sel = sel; reg_we = 1'b1; reg_addr = ofs; reg_wdata = val;
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0;
        if (sel && ofs == 8'h23) m_dat = val;
        if (sel && ofs == 8'h27) m_mode = val;
    endtask

    task automatic reg_read(input string req, input logic [7:0] ofs, input logic [7:0] exp);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b0; reg_addr = ofs;
        #1 check(req, reg_rdata, exp);
        @(negedge clk);
        reg_sel = 1'b0;
    endtask

    task automatic drive_bus(input string req, input logic v, input logic [15:0] a);
        @(negedge clk);
        bus_valid = v; bus_addr = a;
        #1 check(req, pin_out, ref_pins(v, a));
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 64; i++) begin
            drive_bus(req, 1'b1, 16'(i * 16'h0400 + (i % 4) * 16'h0155));
            drive_bus(req, 1'b0, 16'(i * 16'h0400));
        end
        foreach (edges[k]) drive_bus(req, 1'b1, edges[k]);
    endtask

    logic [15:0] edges [12] = '{16'h0000, 16'h0FFF, 16'h1000, 16'h1FFF, 16'h2000,
                                16'h3FFF, 16'h4000, 16'h6FFF, 16'h7000, 16'h7FFF,
                                16'h8000, 16'hFFFF};

    task automatic t_reset;
        @(negedge clk); #1;
        check("R1 pins", pin_out, 8'hFF);
        reg_read("R1 data", 8'h23, 8'hFF);
        reg_read("R1 mode", 8'h27, 8'h00);
        drive_bus("R1 pins under access", 1'b1, 16'h8000);
    endtask

    task automatic t_data_mode;
        reg_write(8'h23, 8'h5A, 1'b1);
        drive_bus("R2 data 5A", 1'b1, 16'h1234);
        check("R2 literal", pin_out, 8'h5A);
        reg_write(8'h23, 8'h00, 1'b1);
        sweep("R2 data 00");
    endtask

    task automatic t_cs_mode;
        reg_write(8'h27, 8'hFF, 1'b1);
        reg_write(8'h23, 8'h00, 1'b1);
        sweep("R4 all cs data 00");
        reg_write(8'h23, 8'hFF, 1'b1);
        drive_bus("R3 data ignored", 1'b1, 16'h9000);
        check("R3 literal", pin_out, 8'hF7);
        drive_bus("R5 idle", 1'b0, 16'h9000);
        check("R5 literal", pin_out, 8'hFF);
        drive_bus("R4 window 2 top", 1'b1, 16'h3FFF);
        check("R4 literal", pin_out, 8'hFB);
    endtask

    task automatic t_fb;
        reg_write(8'h27, 8'hFB, 1'b1);
        reg_write(8'h23, 8'h04, 1'b1);
        drive_bus("R9 pin2 high", 1'b1, 16'h2100);
        check("R9 literal", pin_out, 8'hFF);
        reg_write(8'h23, 8'hFB, 1'b1);
        drive_bus("R9 pin2 low", 1'b0, 16'h0000);
        check("R9 literal low", pin_out, 8'hFB);
        sweep("R9 sweep");
    endtask

    task automatic t_mixed;
        reg_write(8'h27, 8'hA5, 1'b1);
        reg_write(8'h23, 8'h3C, 1'b1);
        sweep("R2/R3 mixed A5/3C");
    endtask

    task automatic t_timing;
        // Mode change takes effect the cycle after the write edge.
        reg_write(8'h27, 8'h00, 1'b1);
        reg_write(8'h23, 8'hFF, 1'b1);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = 16'h8000;
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = 8'h27; reg_wdata = 8'h08;
        #1 check("R6 before edge", pin_out, 8'hFF);
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0; m_mode = 8'h08;
        #1 check("R6 after edge", pin_out, 8'hF7);
    endtask

    task automatic t_ignored;
        reg_write(8'h23, 8'h11, 1'b0);
        reg_write(8'h27, 8'h22, 1'b0);
        reg_write(8'h24, 8'h33, 1'b1);
        reg_write(8'h26, 8'h44, 1'b1);
        reg_read("R7 data kept", 8'h23, 8'hFF);
        reg_read("R7 mode kept", 8'h27, 8'h08);
        drive_bus("R7 pins", 1'b0, 16'h0000);
    endtask

    task automatic t_readback;
        reg_read("R8 other offset", 8'h25, 8'h00);
        reg_write(8'h27, 8'hFF, 1'b1);
        reg_write(8'h23, 8'h69, 1'b1);
        bus_valid = 1'b1; bus_addr = 16'h8000;
        reg_read("R8 data not pins", 8'h23, 8'h69);
        reg_read("R8 mode", 8'h27, 8'hFF);
        @(negedge clk);
        reg_sel = 1'b0; reg_addr = 8'h23;
        #1 check("R8 no select", reg_rdata, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_data_mode();
        t_cs_mode();
        t_fb();
        t_mixed();
        t_timing();
        t_ignored();
        t_readback();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule